// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block sits between a set of interrupt request lines and a processor core. It accepts up to 32 ordinary request lines and one non-maskable request. For each ordinary line, configuration selects edge or level capture, an enable bit and a two-bit priority. The block keeps a pending bit per line and arbitrates among the lines that are both pending and enabled. It hands the core one winner as a line number and a valid flag, both from registers.

The core takes a presented request by pulsing an acknowledge with the line number. That clears an edge-captured pending bit and records the line's priority as active. A separate end-of-handler pulse retires the most urgent active level. While a handler runs, only a strictly more urgent request is presented. When a handler ends, the next eligible request appears on the following cycle, so back-to-back handlers do not pass through an idle state. The non-maskable request ignores enables and priorities and is blocked only while its own handler runs. Configuration uses a small register write port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `req_valid` is 0, every line is disabled, every line is in level mode and every priority is 0.
- R2: A write with `cfg_addr`=0 loads the enable bits (bit i enables line i). `cfg_addr`=1 loads the mode bits (bit i = 1 selects edge capture for line i). `cfg_addr`=2 loads the priorities of lines 0 to 15, and `cfg_addr`=3 loads those of lines 16 to 31, with line i using bits [2*(i%16)+1 : 2*(i%16)] of the word.
- R3: In edge mode, a rising input sets the pending bit. The bit stays set after the input falls, until that line is acknowledged.
- R4: In level mode, the pending bit follows the input. An acknowledge does not clear it while the input is still high.
- R5: A disabled line can become pending but is never presented. Enabling it later presents it if it is still pending.
- R6: Among eligible lines, a numerically lower priority value wins, and 0 is the most urgent.
- R7: When eligible lines share the best priority, the lowest line number wins.
- R8: A rising edge on `nmi_in` is presented as id 32 ahead of every ordinary line, whatever the enables and priorities. Acknowledging id 32 clears it, and no ordinary line is presented while its handler runs.
- R9: `req_valid` and `req_id` are registered. They change one cycle after a pending or enable change, so an input edge shows two clock edges after it is sampled.
- R10: An acknowledge clears the named edge-mode pending bit at that clock edge. A new rising edge at the same edge sets the bit again.
- R11: During a handler, only a strictly more urgent request is presented. An end-of-handler pulse retires the most urgent active level, and the next eligible request appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Ordinary interrupt request lines |
| nmi_in | input | 1 | Non-maskable request, edge captured |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| ack_valid | input | 1 | Core takes the request named by ack_id |
| ack_id | input | 6 | Acknowledged id, 0..NUM_LINES-1 or 32 |
| eoi | input | 1 | Core finished the most urgent active handler |
| req_valid | output | 1 | A request is presented |
| req_id | output | 6 | Presented id, 32 for the non-maskable request |

## Verification
An input edge that arrives at a falling clock edge is captured into pending at the next rising edge. It is seen in `req_id` one rising edge after that, so the bench samples two cycles on and also checks that one cycle on is still too early. A configuration write or an end-of-handler pulse moves state at its own rising edge and the presented request one edge later, so those checks sample one cycle after the strobe drops. After an acknowledge, the output still shows the old winner for one cycle. The bench therefore always issues the end-of-handler pulse, or waits a cycle, before it samples.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int PRIO_W    = 2;
   localparam int NUM_LVL   = 1 << PRIO_W;
   localparam int ID_W      = 6;
   localparam int MAX_LINES = 32;
   localparam int LINES_PER_WORD = 32 / PRIO_W;
   localparam logic [ID_W-1:0] NMI_ID = ID_W'(32);
   typedef logic [PRIO_W-1:0] prio_t;
   typedef logic [PRIO_W:0]   run_t;
endpackage

// File: rtl/pic_pend_cell.sv
module pic_pend_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_i,
   input  logic pulse_i,
   input  logic clr_i,
   output logic pend_o
);
   logic prev_q;
   logic rise;

   assign rise = irq_i & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_o <= 1'b0;
      end else begin
         prev_q <= irq_i;
         if (pulse_i) pend_o <= (pend_o & ~clr_i) | rise;
         else         pend_o <= irq_i;
      end
   end

   AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_i |=> (pend_o == $past(irq_i))); // R4
   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_i && pend_o && !clr_i) |=> pend_o); // R3
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_i && clr_i && !rise) |=> !pend_o); // R10
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
   import pic_pkg::*;
#(
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_i,
   input  logic [1:0]           addr_i,
   input  logic [31:0]          wdata_i,
   output logic [NUM_LINES-1:0] en_o,
   output logic [NUM_LINES-1:0] pulse_o,
   output prio_t [NUM_LINES-1:0] prio_o
);
   logic unused_wdata;
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_o    <= '0;
         pulse_o <= '0;
      end else if (we_i) begin
         if (addr_i == 2'd0) en_o    <= wdata_i[NUM_LINES-1:0];
         if (addr_i == 2'd1) pulse_o <= wdata_i[NUM_LINES-1:0];
      end
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_prio
      localparam int WORD  = i / LINES_PER_WORD;
      localparam int FIELD = i % LINES_PER_WORD;
      always_ff @(posedge clk) begin
         if (!rst_n) prio_o[i] <= '0;
         else if (we_i && addr_i == 2'(2 + WORD))
            prio_o[i] <= wdata_i[PRIO_W*FIELD +: PRIO_W];
      end
   end
endmodule

// File: rtl/pic_nest.sv
module pic_nest
   import pic_pkg::*;
#(
   parameter int NUM_LINES = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ack_valid_i,
   input  logic [ID_W-1:0] ack_id_i,
   input  prio_t           ack_prio_i,
   input  logic            eoi_i,
   output run_t            run_lvl_o,
   output logic            nmi_act_o
);
   localparam logic [ID_W-1:0] N_ID = ID_W'(NUM_LINES);

   logic [NUM_LVL-1:0] lvl_q, lvl_n;
   logic               nmi_n;
   logic               popped;

   always_comb begin
      lvl_n  = lvl_q;
      nmi_n  = nmi_act_o;
      popped = 1'b0;
      if (eoi_i) begin
         if (nmi_act_o) nmi_n = 1'b0;
         else begin
            for (int l = 0; l < NUM_LVL; l++) begin
               if (lvl_q[l] && !popped) begin
                  lvl_n[l] = 1'b0;
                  popped   = 1'b1;
               end
            end
         end
      end
      if (ack_valid_i) begin
         if (ack_id_i == NMI_ID)  nmi_n = 1'b1;
         else if (ack_id_i < N_ID) lvl_n[ack_prio_i] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q     <= '0;
         nmi_act_o <= 1'b0;
      end else begin
         lvl_q     <= lvl_n;
         nmi_act_o <= nmi_n;
      end
   end

   always_comb begin
      run_lvl_o = run_t'(NUM_LVL);
      for (int l = NUM_LVL - 1; l >= 0; l--)
         if (lvl_q[l]) run_lvl_o = run_t'(l);
   end

   AST_NEST_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid_i && ack_id_i < N_ID) |=> (run_lvl_o <= {1'b0, $past(ack_prio_i)})); // R11
   AST_NMI_NEST: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid_i && ack_id_i == NMI_ID) |=> nmi_act_o); // R8
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
   import pic_pkg::*;
#(
   parameter int NUM_LINES = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LINES-1:0]  pend_i,
   input  logic [NUM_LINES-1:0]  en_i,
   input  prio_t [NUM_LINES-1:0] prio_i,
   input  logic                  nmi_pend_i,
   input  logic                  nmi_act_i,
   input  run_t                  run_lvl_i,
   output logic                  req_valid_o,
   output logic [ID_W-1:0]       req_id_o
);
   localparam logic [ID_W-1:0] N_ID = ID_W'(NUM_LINES);

   logic            best_v;
   logic [ID_W-1:0] best_id;
   prio_t           best_p;
   logic            win_v;
   logic [ID_W-1:0] win_id;

   always_comb begin
      best_v  = 1'b0;
      best_id = '0;
      best_p  = '1;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (pend_i[i] && en_i[i] && (!best_v || prio_i[i] < best_p)) begin
            best_v  = 1'b1;
            best_id = ID_W'(i);
            best_p  = prio_i[i];
         end
      end
   end

   always_comb begin
      win_v  = 1'b0;
      win_id = '0;
      if (nmi_pend_i && !nmi_act_i) begin
         win_v  = 1'b1;
         win_id = NMI_ID;
      end else if (best_v && !nmi_act_i && ({1'b0, best_p} < run_lvl_i)) begin
         win_v  = 1'b1;
         win_id = best_id;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_valid_o <= 1'b0;
         req_id_o    <= '0;
      end else begin
         req_valid_o <= win_v;
         req_id_o    <= win_id;
      end
   end

   AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pend_i && !nmi_act_i) |=> (req_valid_o && req_id_o == NMI_ID)); // R8
   AST_ID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> (req_id_o < N_ID || req_id_o == NMI_ID)); // R6
   AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && req_id_o < N_ID) |-> |($past(en_i) & (NUM_LINES'(1) << req_id_o))); // R5
   AST_NO_ORD_IN_NMI: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_act_i && !nmi_pend_i) |=> !req_valid_o); // R8
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 nmi_in,
   input  logic                 cfg_we,
   input  logic [1:0]           cfg_addr,
   input  logic [31:0]          cfg_wdata,
   input  logic                 ack_valid,
   input  logic [5:0]           ack_id,
   input  logic                 eoi,
   output logic                 req_valid,
   output logic [5:0]           req_id
);
   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("prio_irq_ctrl: NUM_LINES must lie in 1..32");
   end

   logic [NUM_LINES-1:0]  en_vec, pulse_vec, pend_vec;
   prio_t [NUM_LINES-1:0] prio_vec;
   prio_t                 ack_prio;
   logic                  nmi_pend, nmi_act, nmi_clr;
   run_t                  run_lvl;

   pic_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
      .wdata_i(cfg_wdata), .en_o(en_vec), .pulse_o(pulse_vec), .prio_o(prio_vec)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic clr;
      assign clr = ack_valid && (ack_id == ID_W'(i));
      pic_pend_cell u_cell (
         .clk(clk), .rst_n(rst_n), .irq_i(irq_in[i]), .pulse_i(pulse_vec[i]),
         .clr_i(clr), .pend_o(pend_vec[i])
      );
   end

   assign nmi_clr = ack_valid && (ack_id == NMI_ID);

   pic_pend_cell u_nmi_cell (
      .clk(clk), .rst_n(rst_n), .irq_i(nmi_in), .pulse_i(1'b1),
      .clr_i(nmi_clr), .pend_o(nmi_pend)
   );

   always_comb begin
      ack_prio = '0;
      for (int i = 0; i < NUM_LINES; i++)
         if (ack_id == ID_W'(i)) ack_prio = prio_vec[i];
   end

   pic_nest #(.NUM_LINES(NUM_LINES)) u_nest (
      .clk(clk), .rst_n(rst_n), .ack_valid_i(ack_valid), .ack_id_i(ack_id),
      .ack_prio_i(ack_prio), .eoi_i(eoi), .run_lvl_o(run_lvl), .nmi_act_o(nmi_act)
   );

   pic_arbiter #(.NUM_LINES(NUM_LINES)) u_arb (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_vec), .en_i(en_vec), .prio_i(prio_vec),
      .nmi_pend_i(nmi_pend), .nmi_act_i(nmi_act), .run_lvl_i(run_lvl),
      .req_valid_o(req_valid), .req_id_o(req_id)
   );
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq = '0;
   logic         nmi = 1'b0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_addr = '0;
   logic [31:0]  cfg_wdata = '0;
   logic         ack_valid = 1'b0;
   logic [5:0]   ack_id = '0;
   logic         eoi = 1'b0;
   logic         req_valid;
   logic [5:0]   req_id;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   prio_irq_ctrl #(.NUM_LINES(N)) dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq), .nmi_in(nmi),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .ack_valid(ack_valid), .ack_id(ack_id), .eoi(eoi),
      .req_valid(req_valid), .req_id(req_id)
   );

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // expected -1 means no request presented
   task automatic chk_req(input string rq, input int exp);
      int act;
      act = req_valid ? int'(req_id) : -1;
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic ack(input int id);
      ack_valid = 1'b1; ack_id = 6'(id);
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   task automatic end_handler();
      eoi = 1'b1;
      @(negedge clk);
      eoi = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      chk_req("R1 reset idle", -1);
      irq[0] = 1'b1; cyc(2); irq[0] = 1'b0;
      chk_req("R1 disabled after reset", -1);
      cyc(2);

      wr(2'd0, 32'hFF);
      cyc(1);
      chk_req("R1 level-mode pending gone", -1);
      wr(2'd1, 32'hFF);

      // sweep every line pair and priority pair
      for (int a = 0; a < N; a++) begin
         for (int b = 0; b < N; b++) begin
            for (int pa = 0; pa < 4; pa++) begin
               for (int pb = 0; pb < 4; pb++) begin
                  int win, oth, word;
                  string rq;
                  if (a == b && pb != 0) continue;
                  word = (a == b) ? (pa << (2*a)) : ((pa << (2*a)) | (pb << (2*b)));
                  wr(2'd2, 32'(word));
                  if (a == b)       begin win = a; oth = a; rq = "R3"; end
                  else if (pa < pb) begin win = a; oth = b; rq = "R6"; end
                  else if (pb < pa) begin win = b; oth = a; rq = "R6"; end
                  else begin
                     win = (a < b) ? a : b; oth = (a < b) ? b : a; rq = "R7";
                  end
                  irq[a] = 1'b1; irq[b] = 1'b1;
                  cyc(2);
                  irq = '0;
                  chk_req(rq, win);
                  ack(win);
                  end_handler();
                  cyc(1);
                  if (a != b) begin
                     chk_req("R11 tail chain", oth);
                     ack(oth);
                     end_handler();
                     cyc(1);
                  end
                  chk_req("R3 cleared by ack", -1);
               end
            end
         end
      end

      // R9 timing and R5 disable
      wr(2'd2, 32'h0);
      irq[7] = 1'b1;
      cyc(1);
      chk_req("R9 too early", -1);
      cyc(1);
      irq[7] = 1'b0;
      chk_req("R9 two edges", 7);
      ack(7); end_handler(); cyc(1);
      wr(2'd0, 32'hF7);
      irq[3] = 1'b1; cyc(2); irq[3] = 1'b0;
      chk_req("R5 disabled held", -1);
      wr(2'd0, 32'hFF);
      cyc(1);
      chk_req("R5 enable presents", 3);
      ack(3); end_handler(); cyc(1);
      chk_req("R5 cleared", -1);

      // R11 preemption: line2 prio2, line5 prio2, line6 prio1
      wr(2'd2, (32'd2 << 4) | (32'd2 << 10) | (32'd1 << 12));
      irq[2] = 1'b1; cyc(2); irq[2] = 1'b0;
      chk_req("R11 first", 2);
      ack(2);
      irq[5] = 1'b1; cyc(2); irq[5] = 1'b0;
      chk_req("R11 equal waits", -1);
      irq[6] = 1'b1; cyc(2); irq[6] = 1'b0;
      chk_req("R11 higher preempts", 6);
      ack(6);
      end_handler(); cyc(1);
      chk_req("R11 outer still blocks", -1);
      end_handler(); cyc(1);
      chk_req("R11 tail after nest", 5);
      ack(5); end_handler(); cyc(1);
      chk_req("R11 idle", -1);

      // R8 non-maskable
      wr(2'd0, 32'h0);
      nmi = 1'b1; cyc(2); nmi = 1'b0;
      chk_req("R8 unmaskable", 32);
      ack(32);
      wr(2'd0, 32'hFF);
      irq[6] = 1'b1; cyc(2); irq[6] = 1'b0;
      chk_req("R8 blocks ordinary", -1);
      end_handler(); cyc(1);
      chk_req("R8 ordinary after", 6);
      nmi = 1'b1; cyc(2); nmi = 1'b0;
      chk_req("R8 beats pending line", 32);
      ack(32); end_handler(); cyc(1);
      chk_req("R8 back to line", 6);
      ack(6); end_handler(); cyc(1);

      // R4 level mode on line 1
      wr(2'd1, 32'hFD);
      irq[1] = 1'b1; cyc(2);
      chk_req("R4 level presented", 1);
      ack(1); end_handler(); cyc(1);
      chk_req("R4 ack no clear", 1);
      irq[1] = 1'b0; cyc(2);
      chk_req("R4 follows input", -1);

      // R10 ack and new edge at the same clock edge
      irq[4] = 1'b1; cyc(2);
      chk_req("R10 presented", 4);
      irq[4] = 1'b0; cyc(1);
      ack_valid = 1'b1; ack_id = 6'd4; irq[4] = 1'b1;
      @(negedge clk);
      ack_valid = 1'b0; irq[4] = 1'b0;
      end_handler(); cyc(1);
      chk_req("R10 re-set wins", 4);
      ack(4); end_handler(); cyc(1);
      chk_req("R10 cleared", -1);

      // R2 upper half of a word: line 7 prio 0 beats line 0 prio 3
      wr(2'd2, (32'd3 << 0) | (32'd0 << 14));
      irq[0] = 1'b1; irq[7] = 1'b1; cyc(2); irq = '0;
      chk_req("R2 priority field", 7);
      ack(7); end_handler(); cyc(1);
      chk_req("R2 then line 0", 0);
      ack(0); end_handler(); cyc(1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule